// File: doc/BRIEF.md
# Segmented Instruction Fetch Sequencer

This block holds a 16-bit code segment and a 16-bit instruction pointer, and uses them to fetch instruction bytes. It forms a 20-bit physical address by shifting the segment left four places and adding the offset. It reads one byte per accepted request from a memory port that uses a valid/ready handshake. The byte goes into a small buffer that always starts at the current segment:pointer.

A decode stub outside the block looks at the buffered bytes and reports the length of the instruction at the head. Once the buffer holds that many bytes, the block presents the instruction. When the consumer accepts it, the block drops those bytes from the buffer and moves the pointer past them.

The block takes two redirect commands. A far jump loads a new segment and a new pointer. A register jump loads a new pointer and keeps the segment. Either redirect discards everything fetched from the old path.

Top module: `seg_fetch_unit`

## Requirements
- R1: After reset the segment is FFFFH, the pointer is 0000H, the buffer is empty and no instruction is valid, so the first request goes to physical address FFFF0H.
- R2: The request address is ((segment << 4) + offset) mod 2^20, where offset = (pointer + bytes already buffered) mod 2^16. A carry out of bit 19 is dropped.
- R3: A request is raised only while fewer than six bytes are buffered. A byte is stored only on a cycle with both request valid and ready high. While ready is low, the request address holds.
- R4: An instruction is valid once the buffer holds at least the reported length. On `insn_bytes`, byte i sits at bits [8i+7:8i] and is the memory byte at segment:(pointer+i) mod 2^16. `insn_seg` and `insn_ptr` give the instruction's own location.
- R5: When an instruction is accepted (valid and ready both high), the pointer advances by its length modulo 2^16 and the segment is unchanged.
- R6: A far jump loads both the segment and the pointer from its inputs. For example, 2AE3:0003 gives segment 2AE3H and pointer 0003H.
- R7: A register jump loads only the pointer from the register value input and leaves the segment unchanged.
- R8: When a far jump and a register jump arrive in the same cycle, the far jump wins.
- R9: A redirect takes priority over accepting an instruction. In the redirect cycle the instruction is not valid, the pointer does not advance, and all buffered bytes are discarded, including any byte accepted from memory in that cycle.
- R10: A reported length of 0, or of more than 6, never makes an instruction valid, and the pointer stays where it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_req_valid | output | 1 | Byte read request |
| mem_req_addr | output | 20 | Physical byte address |
| mem_req_ready | input | 1 | Memory accepts the request; data is valid the same cycle |
| mem_rdata | input | 8 | Byte returned for the accepted request |
| dec_len | input | 3 | Instruction length reported by the decode stub |
| insn_valid | output | 1 | A complete instruction is presented |
| insn_ready | input | 1 | Consumer accepts the instruction |
| insn_bytes | output | 48 | Buffered bytes, byte 0 in the low bits |
| insn_seg | output | 16 | Current code segment |
| insn_ptr | output | 16 | Current instruction pointer |
| far_jmp | input | 1 | Far jump command |
| far_seg | input | 16 | Far jump segment |
| far_off | input | 16 | Far jump offset |
| reg_jmp | input | 1 | Register jump command |
| reg_val | input | 16 | Register jump pointer value |

## Verification
The bench targets the two wrap points.
- A far jump to FFFF:FFF0 must fetch from 0FFE0H. A design that kept the 21st bit, or that truncated the offset first, would fetch the wrong bytes.
- A pointer at FFFEH with a 3-byte instruction must read the third byte from segment:0000 and then step to 0001H. A design that carried into the segment would show a changed segment.

It also targets the redirect cases:
- A redirect issued while the buffer is full and the consumer is ready must leave the old head unconsumed and must show the new target's bytes. A design that skipped the flush would present stale bytes.
- A far jump and a register jump issued together must land on the far target.

Finally, lengths of 0 and 7 and a stalled memory port must leave the block idle, with its address held.

// File: rtl/seg_fetch_pkg.sv
// Package: shared widths, reset values and the redirect select type for
// the segmented fetch sequencer.
// Assumes: the physical address is exactly the segment width plus the shift.
package seg_fetch_pkg;
    localparam int SEG_W     = 16;
    localparam int PTR_W     = 16;
    localparam int SEG_SHIFT = 4;
    localparam int PA_W      = SEG_W + SEG_SHIFT;
    localparam int BYTE_W    = 8;

    localparam logic [SEG_W-1:0] RESET_SEG = 16'hFFFF;
    localparam logic [PTR_W-1:0] RESET_PTR = 16'h0000;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_REG  = 2'd1,
        RD_FAR  = 2'd2
    } redirect_e;
endpackage

// File: rtl/seg_addr_gen.sv
// Module: seg_addr_gen
// Forms the physical fetch address from segment, pointer and the number of
// bytes already buffered ahead of the pointer.
// Assumes: the offset wraps in 16 bits and the sum wraps in PA_W bits.
module seg_addr_gen
    import seg_fetch_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [PTR_W-1:0] ptr,
    input  logic [CNT_W-1:0] fill,
    output logic [PA_W-1:0]  phys
);
    logic [PTR_W-1:0] fetch_off;

    // Offset of the next byte to fetch, wrapped within the segment.
    always_comb fetch_off = ptr + PTR_W'(fill);

    // Shifted segment plus offset, with the carry out of the top bit dropped.
    always_comb phys = {seg, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, fetch_off};
endmodule

// File: rtl/seg_ptr_regs.sv
// Module: seg_ptr_regs
// Holds the code segment and instruction pointer. It applies redirects with
// far-over-register priority, and pointer advances when no redirect occurs.
// Assumes: adv is only raised for a legal length; the advance wraps in 16 bits.
module seg_ptr_regs
    import seg_fetch_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             far_jmp,
    input  logic [SEG_W-1:0] far_seg,
    input  logic [PTR_W-1:0] far_off,
    input  logic             reg_jmp,
    input  logic [PTR_W-1:0] reg_val,
    input  logic             adv,
    input  logic [LEN_W-1:0] adv_len,
    output logic             redirect,
    output logic [SEG_W-1:0] seg_q,
    output logic [PTR_W-1:0] ptr_q
);
    redirect_e sel;

    // Pick the winning redirect source; the far jump outranks the register jump.
    always_comb begin
        if (far_jmp)      sel = RD_FAR;
        else if (reg_jmp) sel = RD_REG;
        else              sel = RD_NONE;
    end

    assign redirect = (sel != RD_NONE);

    // Update segment and pointer: reset, redirect, then sequential advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= RESET_SEG;
            ptr_q <= RESET_PTR;
        end else begin
            unique case (sel)
                RD_FAR: begin
                    seg_q <= far_seg;
                    ptr_q <= far_off;
                end
                RD_REG:  ptr_q <= reg_val;
                default: if (adv) ptr_q <= ptr_q + PTR_W'(adv_len);
            endcase
        end
    end

    assert_far_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        far_jmp |=> (seg_q == $past(far_seg)) && (ptr_q == $past(far_off)));

    assert_reg_keeps_seg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_jmp && !far_jmp) |=> $stable(seg_q) && (ptr_q == $past(reg_val)));

    assert_far_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (far_jmp && reg_jmp) |=> (ptr_q == $past(far_off)));

    assert_advance_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !far_jmp && !reg_jmp) |=>
            $stable(seg_q) && (ptr_q == PTR_W'($past(ptr_q) + PTR_W'($past(adv_len)))));
endmodule

// File: rtl/seg_fetch_buf.sv
// Module: seg_fetch_buf
// A byte buffer whose slot 0 always holds the byte at the current pointer.
// A pop drops the leading bytes, a push appends one byte behind the valid
// ones, and a flush empties the buffer (a push in the same cycle is dropped).
// Assumes: push only while not full; pop_len never exceeds the count.
module seg_fetch_buf
    import seg_fetch_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int CNT_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      push,
    input  logic [BYTE_W-1:0]         push_data,
    input  logic                      pop,
    input  logic [CNT_W-1:0]          pop_len,
    output logic [CNT_W-1:0]          count,
    output logic                      full,
    output logic [DEPTH*BYTE_W-1:0]   bytes_flat
);
    logic [BYTE_W-1:0] slot_q [DEPTH];
    logic [BYTE_W-1:0] slot_d [DEPTH];
    logic [CNT_W-1:0]  cnt_q, cnt_d, base;

    // Next slot contents and fill level after flush, pop and push.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) slot_d[i] = slot_q[i];
        base  = cnt_q;
        cnt_d = cnt_q;
        if (flush) begin
            cnt_d = '0;
        end else begin
            if (pop) begin
                base = cnt_q - pop_len;
                for (int i = 0; i < DEPTH; i++) begin
                    slot_d[i] = '0;
                    for (int j = 0; j < DEPTH; j++)
                        if (j == i + int'(pop_len)) slot_d[i] = slot_q[j];
                end
            end
            if (push) begin
                for (int i = 0; i < DEPTH; i++)
                    if (i == int'(base)) slot_d[i] = push_data;
                cnt_d = base + CNT_W'(1);
            end else begin
                cnt_d = base;
            end
        end
    end

    // Fill level register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Byte storage; contents beyond the fill level are don't-care.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
    end

    assign count = cnt_q;
    assign full  = (cnt_q == CNT_W'(DEPTH));

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_flat
            assign bytes_flat[g*BYTE_W +: BYTE_W] = slot_q[g];
        end
    endgenerate

    assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt_q == '0));
endmodule

// File: rtl/seg_fetch_unit.sv
// Module: seg_fetch_unit (top)
// Segmented instruction fetch sequencer. Segment and pointer registers drive
// an address adder. The adder fetches bytes into a buffer, which presents an
// instruction once the decode stub's reported length is covered.
// Assumes: memory data is valid in the same cycle as mem_req_ready.
module seg_fetch_unit
    import seg_fetch_pkg::*;
#(
    parameter int MAX_LEN = 6,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    output logic                        mem_req_valid,
    output logic [PA_W-1:0]             mem_req_addr,
    input  logic                        mem_req_ready,
    input  logic [BYTE_W-1:0]           mem_rdata,
    input  logic [LEN_W-1:0]            dec_len,
    output logic                        insn_valid,
    input  logic                        insn_ready,
    output logic [MAX_LEN*BYTE_W-1:0]   insn_bytes,
    output logic [SEG_W-1:0]            insn_seg,
    output logic [PTR_W-1:0]            insn_ptr,
    input  logic                        far_jmp,
    input  logic [SEG_W-1:0]            far_seg,
    input  logic [PTR_W-1:0]            far_off,
    input  logic                        reg_jmp,
    input  logic [PTR_W-1:0]            reg_val
);
    logic             redirect;
    logic             consume;
    logic             fetch_take;
    logic             buf_full;
    logic             len_legal;
    logic [LEN_W-1:0] fill;
    logic [SEG_W-1:0] seg_q;
    logic [PTR_W-1:0] ptr_q;

    seg_ptr_regs #(.LEN_W(LEN_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .far_jmp  (far_jmp),
        .far_seg  (far_seg),
        .far_off  (far_off),
        .reg_jmp  (reg_jmp),
        .reg_val  (reg_val),
        .adv      (consume),
        .adv_len  (dec_len),
        .redirect (redirect),
        .seg_q    (seg_q),
        .ptr_q    (ptr_q)
    );

    seg_addr_gen #(.CNT_W(LEN_W)) u_addr (
        .seg  (seg_q),
        .ptr  (ptr_q),
        .fill (fill),
        .phys (mem_req_addr)
    );

    seg_fetch_buf #(.DEPTH(MAX_LEN), .CNT_W(LEN_W)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (redirect),
        .push       (fetch_take),
        .push_data  (mem_rdata),
        .pop        (consume),
        .pop_len    (dec_len),
        .count      (fill),
        .full       (buf_full),
        .bytes_flat (insn_bytes)
    );

    // Legal lengths run from one byte up to the buffer depth.
    always_comb len_legal = (dec_len != '0) && (dec_len <= LEN_W'(MAX_LEN));

    // Request a byte whenever there is room; a byte lands on the handshake.
    always_comb begin
        mem_req_valid = !buf_full;
        fetch_take    = mem_req_valid && mem_req_ready;
    end

    // Present an instruction when it is fully buffered and no redirect is pending.
    always_comb begin
        insn_valid = len_legal && (fill >= dec_len) && !redirect;
        consume    = insn_valid && insn_ready;
    end

    assign insn_seg = seg_q;
    assign insn_ptr = ptr_q;

    assert_stall_holds_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready && !redirect) |=> $stable(mem_req_addr));

    assert_legal_len_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid |-> (dec_len >= LEN_W'(1)) && (dec_len <= LEN_W'(MAX_LEN)));

    assert_redirect_blocks_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (far_jmp || reg_jmp) |-> !insn_valid);

    assert_reset_start_R1: assert property (@(posedge clk)
        !rst_n |=> (insn_seg == RESET_SEG) && (insn_ptr == RESET_PTR) && !insn_valid);
endmodule

// File: tb/seg_fetch_unit_bench.sv
// Scoreboard bench: the driver queues expected instructions, the monitor
// pops and compares them as the design issues them.
module seg_fetch_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAXL = 6;

    typedef struct {
        logic [15:0] seg;
        logic [15:0] ptr;
        int          len;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req_valid;
    logic [19:0] mem_req_addr;
    logic        mem_req_ready = 1'b0;
    logic [7:0]  mem_rdata;
    logic [2:0]  dec_len = 3'd1;
    logic        insn_valid;
    logic        insn_ready = 1'b0;
    logic [47:0] insn_bytes;
    logic [15:0] insn_seg;
    logic [15:0] insn_ptr;
    logic        far_jmp = 1'b0;
    logic [15:0] far_seg = '0;
    logic [15:0] far_off = '0;
    logic        reg_jmp = 1'b0;
    logic [15:0] reg_val = '0;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    bit   stall_mode = 1'b0;
    exp_t q[$];
    logic [15:0] m_seg = 16'hFFFF;
    logic [15:0] m_ptr = 16'h0000;

    seg_fetch_unit u_seg_fetch_unit (
        .clk (clk), .rst_n (rst_n),
        .mem_req_valid (mem_req_valid), .mem_req_addr (mem_req_addr),
        .mem_req_ready (mem_req_ready), .mem_rdata (mem_rdata),
        .dec_len (dec_len), .insn_valid (insn_valid), .insn_ready (insn_ready),
        .insn_bytes (insn_bytes), .insn_seg (insn_seg), .insn_ptr (insn_ptr),
        .far_jmp (far_jmp), .far_seg (far_seg), .far_off (far_off),
        .reg_jmp (reg_jmp), .reg_val (reg_val)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[3:0]} ^ 8'h5A;
    endfunction

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    assign mem_rdata = mem_byte(mem_req_addr);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Monitor: compare every issued instruction against the queue head.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && insn_valid && insn_ready) begin
                if (q.size() == 0) begin
                    check(1'b0, "R4", "unexpected issue ptr", 64'(insn_ptr), 64'hFFFF_FFFF);
                end else begin
                    exp_t e;
                    logic [47:0] want;
                    e = q.pop_front();
                    want = insn_bytes;
                    for (int i = 0; i < e.len; i++)
                        want[i*8 +: 8] = mem_byte(phys(e.seg, e.ptr + 16'(i)));
                    check(insn_seg == e.seg, "R5", "issued segment", 64'(insn_seg), 64'(e.seg));
                    check(insn_ptr == e.ptr, "R5", "issued pointer", 64'(insn_ptr), 64'(e.ptr));
                    check(insn_bytes == want, "R4", "instruction bytes", 64'(insn_bytes), 64'(want));
                end
            end
        end
    end

    // Memory ready toggler used for back-pressure phases.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (stall_mode) mem_req_ready = ~mem_req_ready;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "ALL", "watchdog expired", 64'd0, 64'd1);
        finish_run();
    end

    task automatic run_insns(input int n, input int len);
        dec_len = 3'(len);
        for (int k = 0; k < n; k++) begin
            q.push_back('{seg: m_seg, ptr: m_ptr, len: len});
            m_ptr = m_ptr + 16'(len);
        end
        insn_ready = 1'b1;
        do @(posedge clk); while (q.size() != 0 && !done);
        #1 insn_ready = 1'b0;
    endtask

    task automatic do_far(input logic [15:0] s, input logic [15:0] o);
        far_jmp = 1'b1; far_seg = s; far_off = o;
        @(posedge clk);
        #1 far_jmp = 1'b0;
        m_seg = s; m_ptr = o;
    endtask

    task automatic do_reg(input logic [15:0] v);
        reg_jmp = 1'b1; reg_val = v;
        @(posedge clk);
        #1 reg_jmp = 1'b0;
        m_ptr = v;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, memory held off
        check(insn_seg == 16'hFFFF, "R1", "reset segment", 64'(insn_seg), 64'hFFFF);
        check(insn_ptr == 16'h0000, "R1", "reset pointer", 64'(insn_ptr), 64'h0);
        check(mem_req_addr == 20'hFFFF0, "R1", "first address", 64'(mem_req_addr), 64'hFFFF0);
        check(!insn_valid, "R1", "no instruction after reset", 64'(insn_valid), 64'd0);
        // R3: stalled port keeps the address and buffers nothing
        repeat (4) @(negedge clk);
        check(mem_req_addr == 20'hFFFF0, "R3", "address held while stalled", 64'(mem_req_addr), 64'hFFFF0);
        check(!insn_valid, "R3", "nothing buffered while stalled", 64'(insn_valid), 64'd0);
        @(posedge clk); #1 mem_req_ready = 1'b1;
        repeat (8) @(posedge clk);
        @(negedge clk);
        check(!mem_req_valid, "R3", "no request when full", 64'(mem_req_valid), 64'd0);
        check(mem_req_addr == phys(16'hFFFF, 16'h0006), "R2", "address after six bytes",
              64'(mem_req_addr), 64'(phys(16'hFFFF, 16'h0006)));
        // R10: illegal lengths never issue
        @(posedge clk); #1 dec_len = 3'd0; insn_ready = 1'b1;
        repeat (2) @(negedge clk);
        check(!insn_valid, "R10", "length 0 not issued", 64'(insn_valid), 64'd0);
        check(insn_ptr == 16'h0000, "R10", "pointer kept at length 0", 64'(insn_ptr), 64'd0);
        @(posedge clk); #1 dec_len = 3'd7;
        repeat (2) @(negedge clk);
        check(!insn_valid, "R10", "length 7 not issued", 64'(insn_valid), 64'd0);
        check(insn_ptr == 16'h0000, "R10", "pointer kept at length 7", 64'(insn_ptr), 64'd0);
        @(posedge clk); #1 insn_ready = 1'b0;
        // R4/R5: sequential issue with one-byte instructions
        run_insns(4, 1);
        // R4: six-byte instructions under back-pressure
        stall_mode = 1'b1;
        run_insns(3, MAXL);
        stall_mode = 1'b0;
        #0 mem_req_ready = 1'b1;
        // R6: far jump to 2AE3:0003
        do_far(16'h2AE3, 16'h0003);
        @(negedge clk);
        check(insn_seg == 16'h2AE3, "R6", "far segment", 64'(insn_seg), 64'h2AE3);
        check(insn_ptr == 16'h0003, "R6", "far pointer", 64'(insn_ptr), 64'h3);
        @(posedge clk); #1;
        run_insns(3, 2);
        // R7: register jump keeps the segment
        do_reg(16'h0100);
        @(negedge clk);
        check(insn_seg == 16'h2AE3, "R7", "segment kept", 64'(insn_seg), 64'h2AE3);
        @(posedge clk); #1;
        run_insns(2, 3);
        // R2: physical address wraps past 20 bits
        do_far(16'hFFFF, 16'hFFF0);
        @(negedge clk);
        check(mem_req_addr == 20'h0FFE0, "R2", "20-bit wrap", 64'(mem_req_addr), 64'h0FFE0);
        @(posedge clk); #1;
        run_insns(2, 6);
        // R5: pointer wraps within the segment
        do_far(16'h1234, 16'hFFFE);
        run_insns(2, 3);
        check(insn_seg == 16'h1234, "R5", "segment after pointer wrap", 64'(insn_seg), 64'h1234);
        check(insn_ptr == 16'h0004, "R5", "pointer after wrap", 64'(insn_ptr), 64'h4);
        // R8: both redirects at once
        far_jmp = 1'b1; far_seg = 16'h0040; far_off = 16'h0010;
        reg_jmp = 1'b1; reg_val = 16'h0777;
        @(posedge clk);
        #1 far_jmp = 1'b0; reg_jmp = 1'b0;
        m_seg = 16'h0040; m_ptr = 16'h0010;
        @(negedge clk);
        check(insn_ptr == 16'h0010, "R8", "far wins pointer", 64'(insn_ptr), 64'h10);
        check(insn_seg == 16'h0040, "R8", "far wins segment", 64'(insn_seg), 64'h40);
        @(posedge clk); #1;
        run_insns(1, 1);
        // R9: redirect against a ready consumer with a full buffer
        repeat (8) @(posedge clk);
        #1 dec_len = 3'd1; insn_ready = 1'b1; reg_jmp = 1'b1; reg_val = 16'h5000;
        @(negedge clk);
        check(!insn_valid, "R9", "no issue in redirect cycle", 64'(insn_valid), 64'd0);
        @(posedge clk);
        #1 reg_jmp = 1'b0; insn_ready = 1'b0;
        m_ptr = 16'h5000;
        @(negedge clk);
        check(insn_ptr == 16'h5000, "R9", "redirect beats advance", 64'(insn_ptr), 64'h5000);
        @(posedge clk); #1;
        run_insns(2, 4);
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule